// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five privilege localities owns a shared security-module register interface at any moment. A simple byte register port carries each access. The locality is taken from the address bits above a 4 KB window, and every locality has its own ownership-control byte at offset zero of its window. Software in a locality can ask for the interface, give it back, or take it by force when it runs at a higher locality number than the current owner. A locality that loses ownership by force is marked as having been seized.

The arbiter keeps one owner register (0xFF means nobody owns the interface) and a small set of flags per locality. It sends a one-cycle locality-changed event to the interrupt logic. When the interface must be handed to another locality while a command is running, the arbiter holds an abort request towards the command engine. The handover is finished only when that engine reports that the abort is done or that the command has completed. Locality 4 is written only by hardware, so the bus port can read its byte but cannot change it.

Top module: `loc_arb_top`

## Requirements
- R1: After reset the owner output is 0xFF, the abort request is low, and the control byte of every locality reads 0x80.
- R2: The locality is address bits [14:12], and the control byte sits at offset 0 of its window. A read of any other offset, or of localities 5 to 7, returns 0xFF. A write there has no effect. Control byte bits: bit 7 always 1, bit 6 always 0, bit 5 = this locality owns the interface, bit 4 = been seized, bit 3 = seize (writes only), bit 2 = pending request, bit 1 = request use, bit 0 = the establishment input.
- R3: The pending bit is computed at read time: it is 1 when any other locality has request-use set. Bit 3 always reads 0.
- R4: A write of bit 5 by the owner releases the interface. It passes to the highest-numbered locality with request-use set, or to nobody (0xFF) if no locality has request-use set.
- R5: A write of bit 1 by a non-owner gives that locality ownership at once when nobody owns the interface. Otherwise it only sets that locality's request-use flag.
- R6: A write of bit 5 by a non-owner clears its own request-use flag.
- R7: A seize (bit 3) is accepted only when two conditions hold. First, nobody owns the interface or the requester's number is greater than the owner's. Second, no higher locality has a seize pending. An accepted seize clears the seize flags of all lower localities. When a seize is set, bits 1 and 5 of the same write are ignored.
- R8: At a handover the new owner's request-use and seize flags are cleared. After a seize the old owner keeps its request-use flag and gains been-seized. After a normal handover the old owner loses request-use.
- R9: `locChanged` pulses for one cycle, in the cycle after the owner register changes, and only when the new owner is a locality.
- R10: Writes addressed to locality 4 change nothing.
- R11: A handover to a locality while `cmdBusy` is high raises `abortReq`. Ownership then stays unchanged until `cmdAbortAck` is seen, and the handover completes on that edge. While `abortReq` is high, release and seize writes are ignored.
- R12: Writing 1 to bit 4 clears that locality's been-seized flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busAddr | input | 15 | Byte address shared by reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdata | output | 8 | Read data, combinational from the address |
| estFlag | input | 1 | Establishment status shown in bit 0 |
| cmdBusy | input | 1 | Command engine is executing a command |
| cmdAbortAck | input | 1 | Abort finished or command completed |
| abortReq | output | 1 | Handover is waiting for the command engine |
| locChanged | output | 1 | One-cycle ownership-change event |
| activeLoc | output | 8 | Current owner, 0xFF when nobody owns the interface |

## Verification
A corrupted flag shows up in the next read of a control byte, because the pending bit and the ownership bit are formed from live state. It also shows up at the next release, when the wrong locality, or none, is chosen. The bench therefore reads every affected window right after each write. A wrong owner register or handover rule is visible on `activeLoc` and `locChanged` one cycle after the write edge. A handover that does not wait correctly shows up as `activeLoc` moving while `abortReq` is still high.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LAR_LOCS = 5;
  typedef logic [7:0] loc_id_t;
  localparam loc_id_t NO_LOC = 8'hFF;

  typedef struct packed {
    logic [LAR_LOCS-1:0] setReq;
    logic [LAR_LOCS-1:0] clrReq;
    logic [LAR_LOCS-1:0] clrBeen;
    logic [LAR_LOCS-1:0] setSeize;
    logic [LAR_LOCS-1:0] clrSeize;
    logic                hoGo;
    logic                hoSeize;
    loc_id_t             hoTgt;
  } arb_strobe_t;
endpackage

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = LAR_LOCS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  loc_id_t             wrLoc,
  input  logic                wrOffZero,
  input  logic [7:0]          wrData,
  input  loc_id_t             activeLoc,
  input  logic [NUM_LOC-1:0]  reqUse,
  input  logic [NUM_LOC-1:0]  seizeFlag,
  input  logic                cmdBusy,
  input  logic                cmdAbortAck,
  output logic                abortReq,
  output arb_strobe_t         st
);
  localparam int LOC_W = $clog2(NUM_LOC);
  localparam loc_id_t NUM_ID = loc_id_t'(NUM_LOC);
  localparam loc_id_t HW_LOC = loc_id_t'(NUM_LOC - 1);

  logic    hoPend;
  loc_id_t pendTgt;

  logic [7:0] v;
  logic       wrAcc, ownerValid, isOwner, found, higherSeize, seizeOk, releaseOk;
  logic       hoNeed, seizeHo, immediate;
  loc_id_t    hiReq, tgt;
  logic [LOC_W-1:0] wi;

  always_comb begin
    wi         = wrLoc[LOC_W-1:0];
    wrAcc      = wrEn && wrOffZero && (wrLoc < HW_LOC);
    ownerValid = activeLoc < NUM_ID;
    isOwner    = activeLoc == wrLoc;
    v = wrData;
    if (v[3]) begin
      v[1] = 1'b0;
      v[5] = 1'b0;
    end
    found = 1'b0;
    hiReq = NO_LOC;
    higherSeize = 1'b0;
    for (int c = 0; c < NUM_LOC; c++) begin
      if (reqUse[c]) begin
        found = 1'b1;
        hiReq = loc_id_t'(c);
      end
      if (seizeFlag[c] && loc_id_t'(c) > wrLoc) higherSeize = 1'b1;
    end

    st = '0;
    st.hoTgt = NO_LOC;
    hoNeed = 1'b0;
    seizeHo = 1'b0;
    tgt = NO_LOC;

    releaseOk = wrAcc && v[5] && isOwner && !hoPend;
    if (wrAcc && v[5] && !isOwner) st.clrReq[wi] = 1'b1;
    if (releaseOk) begin
      hoNeed = 1'b1;
      tgt = found ? hiReq : NO_LOC;
    end
    if (wrAcc && v[4]) st.clrBeen[wi] = 1'b1;

    seizeOk = wrAcc && v[3] && !hoPend && (!ownerValid || wrLoc > activeLoc)
              && !seizeFlag[wi] && !higherSeize;
    if (seizeOk) begin
      st.setSeize[wi] = 1'b1;
      for (int c = 0; c < NUM_LOC; c++)
        if (loc_id_t'(c) < wrLoc) st.clrSeize[c] = 1'b1;
      hoNeed = 1'b1;
      seizeHo = 1'b1;
      tgt = wrLoc;
    end

    if (wrAcc && v[1] && !isOwner) begin
      if (ownerValid) st.setReq[wi] = 1'b1;
      else begin
        hoNeed = 1'b1;
        tgt = wrLoc;
      end
    end

    immediate = hoNeed && (!ownerValid || tgt == NO_LOC || !cmdBusy);
    if (immediate) begin
      st.hoGo = 1'b1;
      st.hoTgt = tgt;
      st.hoSeize = seizeHo;
    end else if (hoPend && cmdAbortAck) begin
      st.hoGo = 1'b1;
      st.hoTgt = pendTgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoPend  <= 1'b0;
      pendTgt <= NO_LOC;
    end else if (hoPend && cmdAbortAck) begin
      hoPend  <= 1'b0;
      pendTgt <= NO_LOC;
    end else if (hoNeed && !immediate) begin
      hoPend  <= 1'b1;
      pendTgt <= tgt;
    end
  end

  assign abortReq = hoPend;

  // R11: while waiting for the engine, ownership must not move
  p_abort_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abortReq && !cmdAbortAck) |=> $stable(activeLoc));

  // R10: a write to the hardware-only locality produces no flag update
  p_hw_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrLoc == HW_LOC) |-> ((st.setReq | st.clrReq | st.clrBeen | st.setSeize) == '0));
endmodule

// File: rtl/loc_arb_regs.sv
module loc_arb_regs
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = LAR_LOCS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  arb_strobe_t         st,
  input  loc_id_t             rdLoc,
  input  logic                rdOffZero,
  input  logic                estFlag,
  output logic [7:0]          rdData,
  output loc_id_t             activeLoc,
  output logic [NUM_LOC-1:0]  reqUse,
  output logic [NUM_LOC-1:0]  seizeFlag,
  output logic                locChanged
);
  localparam int LOC_W = $clog2(NUM_LOC);
  localparam loc_id_t NUM_ID = loc_id_t'(NUM_LOC);

  loc_id_t            activeQ, activeD;
  logic [NUM_LOC-1:0] reqQ, reqD, beenQ, beenD, seizeQ, seizeD;
  logic               chgQ, chgD, isSeize, tgtValid;
  logic [LOC_W-1:0]   ti, oi, ri;
  logic [NUM_LOC-1:0] selfMask;

  always_comb begin
    reqD   = (reqQ & ~st.clrReq) | st.setReq;
    beenD  = beenQ & ~st.clrBeen;
    seizeD = (seizeQ & ~st.clrSeize) | st.setSeize;
    activeD = activeQ;
    chgD = 1'b0;
    ti = st.hoTgt[LOC_W-1:0];
    oi = activeQ[LOC_W-1:0];
    tgtValid = st.hoTgt < NUM_ID;
    isSeize = st.hoSeize || (tgtValid && seizeQ[ti]);
    if (st.hoGo && st.hoTgt != activeQ) begin
      if (activeQ < NUM_ID) begin
        if (isSeize) beenD[oi] = 1'b1;
        else         reqD[oi]  = 1'b0;
      end
      if (tgtValid) begin
        reqD[ti]   = 1'b0;
        seizeD[ti] = 1'b0;
        chgD = 1'b1;
      end
      activeD = st.hoTgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= NO_LOC;
      reqQ    <= '0;
      beenQ   <= '0;
      seizeQ  <= '0;
      chgQ    <= 1'b0;
    end else begin
      activeQ <= activeD;
      reqQ    <= reqD;
      beenQ   <= beenD;
      seizeQ  <= seizeD;
      chgQ    <= chgD;
    end
  end

  always_comb begin
    ri = rdLoc[LOC_W-1:0];
    selfMask = '0;
    selfMask[ri] = 1'b1;
    if (rdOffZero && rdLoc < NUM_ID)
      rdData = {1'b1, 1'b0, activeQ == rdLoc, beenQ[ri], 1'b0,
                |(reqQ & ~selfMask), reqQ[ri], estFlag};
    else
      rdData = 8'hFF;
  end

  assign activeLoc  = activeQ;
  assign reqUse     = reqQ;
  assign seizeFlag  = seizeQ;
  assign locChanged = chgQ;

  // R8: the owner never carries a request-use or seize flag
  p_owner_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ < NUM_ID) |-> (!reqQ[activeQ[LOC_W-1:0]] && !seizeQ[activeQ[LOC_W-1:0]]));

  // R7: at most one seize can be outstanding
  p_seize_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seizeQ));

  // R9: the event follows a real change to a locality
  p_change_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locChanged |-> (activeQ != $past(activeQ) && activeQ < NUM_ID));
endmodule

// File: rtl/loc_arb_top.sv
module loc_arb_top
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = LAR_LOCS,
  parameter int LOC_SHIFT = 12,
  parameter int ADDR_W    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWdata,
  input  logic              busRdEn,
  output logic [7:0]        busRdata,
  input  logic              estFlag,
  input  logic              cmdBusy,
  input  logic              cmdAbortAck,
  output logic              abortReq,
  output logic              locChanged,
  output logic [7:0]        activeLoc
);
  loc_id_t            locId, ownerId;
  logic               offZero;
  logic [NUM_LOC-1:0] reqUse, seizeFlag;
  arb_strobe_t        st;
  logic [7:0]         rdData;

  assign locId   = loc_id_t'(busAddr[ADDR_W-1:LOC_SHIFT]);
  assign offZero = busAddr[LOC_SHIFT-1:0] == '0;

  loc_arb_ctrl #(.NUM_LOC(NUM_LOC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(busWrEn), .wrLoc(locId), .wrOffZero(offZero),
    .wrData(busWdata), .activeLoc(ownerId), .reqUse(reqUse), .seizeFlag(seizeFlag),
    .cmdBusy(cmdBusy), .cmdAbortAck(cmdAbortAck), .abortReq(abortReq), .st(st)
  );

  loc_arb_regs #(.NUM_LOC(NUM_LOC)) u_regs (
    .clk(clk), .rst_n(rst_n), .st(st), .rdLoc(locId), .rdOffZero(offZero),
    .estFlag(estFlag), .rdData(rdData), .activeLoc(ownerId), .reqUse(reqUse),
    .seizeFlag(seizeFlag), .locChanged(locChanged)
  );

  assign busRdata  = busRdEn ? rdData : 8'h00;
  assign activeLoc = ownerId;
endmodule

// File: tb/sim_loc_arb_top.sv
`timescale 1ns/1ps
module sim_loc_arb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, estFlag = 1'b0, cmdBusy = 1'b0, cmdAbortAck = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, activeLoc;
  logic abortReq, locChanged;

  int nChk = 0;
  int nFail = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  loc_arb_top u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata),
    .busRdEn(busRdEn), .busRdata(busRdata), .estFlag(estFlag), .cmdBusy(cmdBusy),
    .cmdAbortAck(cmdAbortAck), .abortReq(abortReq), .locChanged(locChanged),
    .activeLoc(activeLoc)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int loc, input int off, input logic [7:0] v);
    @(posedge clk); #1;
    busAddr = 15'((loc << 12) | off);
    busWdata = v;
    busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int loc, input int off, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    busAddr = 15'((loc << 12) | off);
    busRdEn = 1'b1;
    e.exp = exp;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic ack();
    @(posedge clk); #1 cmdAbortAck = 1'b1;
    @(posedge clk); #1 cmdAbortAck = 1'b0;
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (busRdEn) begin
      exp_t e;
      if (q.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL monitor: actual %02h expected none (empty queue)", busRdata);
      end else begin
        e = q.pop_front();
        chk(e.tag, busRdata, e.exp);
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 owner after reset", activeLoc, 8'hFF);
    chk("R1 abortReq after reset", {7'b0, abortReq}, 8'h00);
    rd(0, 0, 8'h80, "R1 loc0 reset byte");
    rd(4, 0, 8'h80, "R1 loc4 reset byte");
    rd(5, 0, 8'hFF, "R2 locality 5 absent");
    rd(1, 4, 8'hFF, "R2 other offset");

    wr(1, 0, 8'h02);
    chk("R5 grant when free", activeLoc, 8'h01);
    chk("R9 pulse on grant", {7'b0, locChanged}, 8'h01);
    rd(1, 0, 8'hA0, "R5 owner byte");

    wr(0, 0, 8'h02);
    chk("R9 no pulse without change", {7'b0, locChanged}, 8'h00);
    rd(0, 0, 8'h82, "R5 request flag set");
    rd(1, 0, 8'hA4, "R3 pending seen by owner");

    wr(2, 0, 8'h02);
    wr(1, 0, 8'h20);
    chk("R4 highest requester wins", activeLoc, 8'h02);
    chk("R9 pulse on release", {7'b0, locChanged}, 8'h01);
    rd(1, 0, 8'h84, "R8 old owner after normal handover");
    rd(2, 0, 8'hA4, "R8 new owner flags cleared");

    wr(0, 0, 8'h20);
    rd(0, 0, 8'h80, "R6 non-owner clears request");
    rd(2, 0, 8'hA0, "R3 pending drops");

    cmdBusy = 1'b1;
    wr(3, 0, 8'h08);
    chk("R11 owner held during abort", activeLoc, 8'h02);
    chk("R11 abortReq raised", {7'b0, abortReq}, 8'h01);
    rd(3, 0, 8'h80, "R3 seize bit reads zero");
    chk("R11 still held", activeLoc, 8'h02);
    ack();
    chk("R7 seize by higher locality", activeLoc, 8'h03);
    chk("R9 pulse on seize", {7'b0, locChanged}, 8'h01);
    chk("R11 abortReq dropped", {7'b0, abortReq}, 8'h00);
    rd(2, 0, 8'h90, "R8 old owner been seized");
    rd(3, 0, 8'hA0, "R8 seizer owns");

    wr(1, 0, 8'h08);
    chk("R7 lower seize rejected", activeLoc, 8'h03);
    chk("R7 no abort on rejection", {7'b0, abortReq}, 8'h00);
    rd(1, 0, 8'h80, "R7 rejected seize leaves flags");

    wr(2, 0, 8'h10);
    rd(2, 0, 8'h80, "R12 been seized cleared");

    wr(4, 0, 8'h02);
    rd(4, 0, 8'h80, "R10 loc4 request ignored");
    rd(3, 0, 8'hA0, "R10 no pending from loc4");
    wr(4, 0, 8'h08);
    chk("R10 loc4 seize ignored", activeLoc, 8'h03);
    chk("R10 loc4 seize no abort", {7'b0, abortReq}, 8'h00);

    wr(3, 4, 8'h20);
    chk("R2 write to other offset ignored", activeLoc, 8'h03);

    wr(3, 0, 8'h20);
    chk("R4 release to nobody", activeLoc, 8'hFF);
    chk("R9 no pulse when freed", {7'b0, locChanged}, 8'h00);
    rd(3, 0, 8'h80, "R4 released byte");

    wr(0, 0, 8'h08);
    chk("R7 seize when free is immediate", activeLoc, 8'h00);
    chk("R9 pulse after free seize", {7'b0, locChanged}, 8'h01);
    rd(0, 0, 8'hA0, "R7 seizer byte");

    cmdBusy = 1'b0;
    wr(2, 0, 8'h08);
    chk("R7 seize immediate when idle", activeLoc, 8'h02);
    rd(0, 0, 8'h90, "R8 been seized on loc0");

    estFlag = 1'b1;
    rd(1, 0, 8'h81, "R2 establishment bit");

    wr(0, 0, 8'h02);
    wr(1, 0, 8'h02);
    wr(2, 0, 8'h20);
    chk("R4 highest of two requesters", activeLoc, 8'h01);
    rd(2, 0, 8'h85, "R3 pending after release");
    rd(1, 0, 8'hA5, "R8 owner with pending");

    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      nChk++; nFail++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    finishRun();
  end
endmodule